// File: doc/BRIEF.md
# Instruction Fetch Sequencer with Return Stack

This block produces the instruction fetch address for a small 8-bit controller core. It keeps a 13-bit logical program counter. Each cycle it updates the counter from a decoded control code: step to the next word, jump, call, or one of three kinds of return. It also holds an eight-level hardware return stack. Only 2K words of program store are physically present, so the fetch address is the low 11 bits of the counter. Any logical address above 07FFh folds back onto the implemented words.

Reset and interrupt entry load fixed vectors. An interrupt acceptance pushes the address of the next instruction before vectoring. The stack is a circular buffer and produces no overflow or underflow indication. A return from interrupt raises a one-cycle strobe, so that outside logic can re-arm interrupts.

Top module: `pc_retstack`

## Requirements
- R1: While `rst` is high at a clock edge, the counter loads 0000h, the stack pointer returns to its base, and `rfi_pulse` goes low. `rst` overrides every other input.
- R2: With `op` = 0 (step), the counter advances by one, wrapping from 1FFFh to 0000h.
- R3: With `op` = 1 (jump), the counter loads {`page_sel`, `target`}, so the next `fetch_addr` equals `target`.
- R4: `fetch_addr` is always the low 11 bits of the counter. Stepping past a logical address whose low bits are 7FFh gives fetch address 000h.
- R5: With `op` = 2 (call), the counter plus one is pushed onto the stack and the counter loads {`page_sel`, `target`}.
- R6: With `op` = 3 (return), 4 (return from interrupt) or 5 (return with literal), the most recently pushed address is popped into the counter.
- R7: The stack holds eight levels in last-in, first-out order. Eight nested calls are unwound by eight returns to the correct addresses.
- R8: A ninth push without a pop overwrites the oldest entry. Eight pops then return the nine pushes, newest first, down to the second push. A further pop returns the ninth push again, because the pointer wraps.
- R9: When `irq_take` is high (and `rst` is low), the counter plus one is pushed and the counter loads 0004h, whatever `op` is.
- R10: `rfi_pulse` is high for exactly the cycle after a return from interrupt is accepted, while the popped address is on `fetch_addr`. It is low after any other operation, or when `irq_take` overrides the return.
- R11: The unused codes `op` = 6 and 7 behave as a step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| irq_take | input | 1 | Interrupt accepted this cycle |
| op | input | 3 | Decoded control code (0 step, 1 jump, 2 call, 3 return, 4 return from interrupt, 5 return with literal) |
| target | input | 11 | Target word field for jump and call |
| page_sel | input | 2 | Upper counter bits for jump and call |
| fetch_addr | output | 11 | Registered physical fetch address |
| rfi_pulse | output | 1 | One-cycle strobe after a return from interrupt |

## Verification
A corrupted stack pointer or entry stays hidden until a later return. At that point `fetch_addr` jumps to a wrong address one cycle after the return is accepted. The nested, overflow and interrupt scenarios therefore unwind every push and compare each landing address. A wrong counter update or vector selection shows on `fetch_addr` in the very next cycle. A misplaced strobe shows on `rfi_pulse` in that same cycle.

// File: rtl/pc_pkg.sv
package pc_pkg;
  typedef enum logic [2:0] {
    OP_STEP  = 3'd0,
    OP_JUMP  = 3'd1,
    OP_CALL  = 3'd2,
    OP_RET   = 3'd3,
    OP_RETI  = 3'd4,
    OP_RETK  = 3'd5
  } pc_op_e;
endpackage

// File: rtl/pc_next_sel.sv
module pc_next_sel
  import pc_pkg::*;
#(
  parameter int PC_W    = 13,
  parameter int PHYS_W  = 11,
  parameter int IRQ_VEC = 4
) (
  input  logic [PC_W-1:0]        pc_q,
  input  logic                   irq_take,
  input  logic [2:0]             op,
  input  logic [PHYS_W-1:0]      target,
  input  logic [PC_W-PHYS_W-1:0] page_sel,
  input  logic [PC_W-1:0]        pop_data,
  output logic [PC_W-1:0]        pc_nxt,
  output logic                   push_en,
  output logic                   pop_en,
  output logic [PC_W-1:0]        push_data,
  output logic                   rfi_hit
);
  logic [PC_W-1:0] pc_inc;
  logic [PC_W-1:0] pc_far;

  assign pc_inc    = pc_q + 1'b1;
  assign pc_far    = {page_sel, target};
  assign push_data = pc_inc;

  always_comb begin
    pc_nxt  = pc_inc;
    push_en = 1'b0;
    pop_en  = 1'b0;
    rfi_hit = 1'b0;
    if (irq_take) begin
      pc_nxt  = PC_W'(IRQ_VEC);
      push_en = 1'b1;
    end else begin
      case (pc_op_e'(op))
        OP_JUMP: pc_nxt = pc_far;
        OP_CALL: begin
          pc_nxt  = pc_far;
          push_en = 1'b1;
        end
        OP_RET, OP_RETK: begin
          pc_nxt = pop_data;
          pop_en = 1'b1;
        end
        OP_RETI: begin
          pc_nxt  = pop_data;
          pop_en  = 1'b1;
          rfi_hit = 1'b1;
        end
        default: pc_nxt = pc_inc;
      endcase
    end
  end
endmodule

// File: rtl/ret_stack.sv
module ret_stack #(
  parameter int DATA_W = 13,
  parameter int DEPTH  = 8,
  localparam int SP_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [SP_W-1:0]   sp
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [SP_W-1:0]   top_idx;

  // Entries carry no reset so the array maps onto distributed RAM.
  always_ff @(posedge clk) begin
    if (push) mem[sp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)       sp <= '0;
    else if (push) sp <= sp + 1'b1;
    else if (pop)  sp <= sp - 1'b1;
  end

  assign top_idx = sp - 1'b1;
  assign rdata   = mem[top_idx];
endmodule

// File: rtl/pc_retstack.sv
module pc_retstack #(
  parameter int PC_W    = 13,
  parameter int PHYS_W  = 11,
  parameter int DEPTH   = 8,
  parameter int RST_VEC = 0,
  parameter int IRQ_VEC = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   irq_take,
  input  logic [2:0]             op,
  input  logic [PHYS_W-1:0]      target,
  input  logic [PC_W-PHYS_W-1:0] page_sel,
  output logic [PHYS_W-1:0]      fetch_addr,
  output logic                   rfi_pulse
);
  localparam int SP_W = $clog2(DEPTH);

  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] pc_nxt;
  logic [PC_W-1:0] push_data;
  logic [PC_W-1:0] pop_data;
  logic            push_en;
  logic            pop_en;
  logic            rfi_hit;
  logic [SP_W-1:0] stk_ptr;

  pc_next_sel #(.PC_W(PC_W), .PHYS_W(PHYS_W), .IRQ_VEC(IRQ_VEC)) u_next (
    .pc_q      (pc_q),
    .irq_take  (irq_take),
    .op        (op),
    .target    (target),
    .page_sel  (page_sel),
    .pop_data  (pop_data),
    .pc_nxt    (pc_nxt),
    .push_en   (push_en),
    .pop_en    (pop_en),
    .push_data (push_data),
    .rfi_hit   (rfi_hit)
  );

  ret_stack #(.DATA_W(PC_W), .DEPTH(DEPTH)) u_stack (
    .clk   (clk),
    .rst   (rst),
    .push  (push_en & ~rst),
    .pop   (pop_en & ~rst),
    .wdata (push_data),
    .rdata (pop_data),
    .sp    (stk_ptr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q      <= PC_W'(RST_VEC);
      rfi_pulse <= 1'b0;
    end else begin
      pc_q      <= pc_nxt;
      rfi_pulse <= rfi_hit;
    end
  end

  // Physical store decodes only the low bits: upper logical pages alias.
  assign fetch_addr = pc_q[PHYS_W-1:0];
endmodule

// File: rtl/pc_retstack_chk.sv
module pc_retstack_chk #(
  parameter int PC_W   = 13,
  parameter int PHYS_W = 11,
  parameter int SP_W   = 3
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   irq_take,
  input logic [2:0]             op,
  input logic [PHYS_W-1:0]      target,
  input logic [PHYS_W-1:0]      fetch_addr,
  input logic                   rfi_pulse,
  input logic [SP_W-1:0]        sp
);
  logic live;
  assign live = !rst && !irq_take;

  // R1
  reset_vec_chk: assert property (@(posedge clk) rst |=> (fetch_addr == '0 && !rfi_pulse && sp == '0));

  // R9
  irq_vec_chk: assert property (@(posedge clk) disable iff (rst)
    irq_take |=> (fetch_addr == PHYS_W'(4) && sp == SP_W'($past(sp) + 1'b1)));

  // R2
  step_inc_chk: assert property (@(posedge clk) disable iff (rst)
    (live && op == 3'd0) |=> fetch_addr == PHYS_W'($past(fetch_addr) + 1'b1));

  // R3
  jump_land_chk: assert property (@(posedge clk) disable iff (rst)
    (live && op == 3'd1) |=> (fetch_addr == $past(target) && $stable(sp)));

  // R5
  call_push_chk: assert property (@(posedge clk) disable iff (rst)
    (live && op == 3'd2) |=> (fetch_addr == $past(target) && sp == SP_W'($past(sp) + 1'b1)));

  // R6
  ret_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (live && (op == 3'd3 || op == 3'd4 || op == 3'd5)) |=> sp == SP_W'($past(sp) - 1'b1));

  // R10
  rfi_set_chk: assert property (@(posedge clk) disable iff (rst)
    (live && op == 3'd4) |=> rfi_pulse);

  // R10
  rfi_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_take || op != 3'd4) |=> !rfi_pulse);
endmodule

bind pc_retstack pc_retstack_chk #(.PC_W(PC_W), .PHYS_W(PHYS_W), .SP_W($clog2(DEPTH))) u_chk (
  .clk        (clk),
  .rst        (rst),
  .irq_take   (irq_take),
  .op         (op),
  .target     (target),
  .fetch_addr (fetch_addr),
  .rfi_pulse  (rfi_pulse),
  .sp         (stk_ptr)
);

// File: tb/pc_retstack_tb.sv
module pc_retstack_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        irq_take = 1'b0;
  logic [2:0]  op = 3'd0;
  logic [10:0] target = '0;
  logic [1:0]  page_sel = '0;
  logic [10:0] fetch_addr;
  logic        rfi_pulse;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  pc_retstack u_dut (
    .clk        (clk),
    .rst        (rst),
    .irq_take   (irq_take),
    .op         (op),
    .target     (target),
    .page_sel   (page_sel),
    .fetch_addr (fetch_addr),
    .rfi_pulse  (rfi_pulse)
  );

  task automatic drive(input logic r, input logic i, input logic [2:0] o,
                       input logic [10:0] t, input logic [1:0] p);
    @(negedge clk);
    rst = r; irq_take = i; op = o; target = t; page_sel = p;
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [10:0] got, input logic [10:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    drive(1'b1, 1'b0, 3'd0, '0, '0);
    drive(1'b0, 1'b0, 3'd1, 11'h000, 2'd0);
  endtask

  task automatic t_reset();
    drive(1'b1, 1'b1, 3'd2, 11'h3AA, 2'd1);
    chk("R1 reset addr", fetch_addr, 11'h000);
    chk("R1 reset strobe", {10'd0, rfi_pulse}, 11'h000);
  endtask

  task automatic t_step();
    drive(1'b0, 1'b0, 3'd1, 11'h100, 2'd0);
    drive(1'b0, 1'b0, 3'd0, '0, '0);
    chk("R2 step", fetch_addr, 11'h101);
    drive(1'b0, 1'b0, 3'd6, 11'h555, 2'd3);
    chk("R11 code 6", fetch_addr, 11'h102);
    drive(1'b0, 1'b0, 3'd7, 11'h555, 2'd3);
    chk("R11 code 7", fetch_addr, 11'h103);
  endtask

  task automatic t_wrap();
    drive(1'b0, 1'b0, 3'd1, 11'h7FE, 2'd1);
    chk("R3 jump paged", fetch_addr, 11'h7FE);
    drive(1'b0, 1'b0, 3'd0, '0, '0);
    chk("R4 top of page", fetch_addr, 11'h7FF);
    drive(1'b0, 1'b0, 3'd0, '0, '0);
    chk("R4 fold above 07FF", fetch_addr, 11'h000);
    drive(1'b0, 1'b0, 3'd1, 11'h7FF, 2'd3);
    drive(1'b0, 1'b0, 3'd0, '0, '0);
    chk("R2 wrap 1FFF", fetch_addr, 11'h000);
  endtask

  task automatic t_nested();
    logic [10:0] ret_at [8];
    logic [10:0] cur;
    do_reset();
    drive(1'b0, 1'b0, 3'd1, 11'h010, 2'd0);
    cur = 11'h010;
    for (int i = 0; i < 8; i++) begin
      ret_at[i] = cur + 11'd1;
      cur = 11'h200 + 11'(i * 16);
      drive(1'b0, 1'b0, 3'd2, cur, 2'(i % 4));
      chk("R5 call lands", fetch_addr, cur);
    end
    for (int i = 7; i >= 0; i--) begin
      logic [2:0] kind;
      kind = 3'd3 + 3'(i % 3);
      drive(1'b0, 1'b0, kind, '0, '0);
      chk("R7 nested return", fetch_addr, ret_at[i]);
      chk("R10 strobe vs kind R6", {10'd0, rfi_pulse}, {10'd0, kind == 3'd4});
    end
  endtask

  task automatic t_overflow();
    logic [10:0] ret_at [9];
    logic [10:0] cur;
    do_reset();
    drive(1'b0, 1'b0, 3'd1, 11'h020, 2'd0);
    cur = 11'h020;
    for (int i = 0; i < 9; i++) begin
      ret_at[i] = cur + 11'd1;
      cur = 11'h300 + 11'(i * 16);
      drive(1'b0, 1'b0, 3'd2, cur, 2'd2);
    end
    for (int i = 8; i >= 1; i--) begin
      drive(1'b0, 1'b0, 3'd3, '0, '0);
      chk("R8 overflow pop", fetch_addr, ret_at[i]);
    end
    drive(1'b0, 1'b0, 3'd5, '0, '0);
    chk("R8 pointer wrap pop", fetch_addr, ret_at[8]);
  endtask

  task automatic t_irq();
    do_reset();
    drive(1'b0, 1'b0, 3'd1, 11'h055, 2'd0);
    drive(1'b0, 1'b1, 3'd1, 11'h123, 2'd0);
    chk("R9 irq vector", fetch_addr, 11'h004);
    drive(1'b0, 1'b0, 3'd0, '0, '0);
    chk("R9 handler step", fetch_addr, 11'h005);
    drive(1'b0, 1'b0, 3'd4, '0, '0);
    chk("R9 resume addr", fetch_addr, 11'h056);
    chk("R10 strobe high", {10'd0, rfi_pulse}, 11'h001);
    drive(1'b0, 1'b0, 3'd0, '0, '0);
    chk("R10 strobe drops", {10'd0, rfi_pulse}, 11'h000);
    drive(1'b0, 1'b1, 3'd4, '0, '0);
    chk("R10 irq over rfi addr", fetch_addr, 11'h004);
    chk("R10 irq over rfi strobe", {10'd0, rfi_pulse}, 11'h000);
    drive(1'b1, 1'b1, 3'd0, '0, '0);
    chk("R1 reset over irq", fetch_addr, 11'h000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog all: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_step();
    t_wrap();
    t_nested();
    t_overflow();
    t_irq();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule